// File: doc/BRIEF.md
# Hash Message Word Ingress

This block sits between the data write port of a hash accelerator and its hash core. A CPU or a DMA engine writes the message as whole 32-bit words. The block rearranges the four byte lanes of each word according to a 2-bit ordering code. It then hands the bytes to the core one per cycle on a valid/ready stream, with a last marker on the final byte of the message.

A configure strobe arms the block. The strobe comes from the register bank when the control register is written. At that moment the block latches the ordering code and the message length in bits. The length in bytes is the bit length divided by eight, with any fractional byte discarded. The block counts bytes down against that length. Every word except the final one contributes four bytes. The final word contributes only the bytes still owed, from one to four, and its surplus lanes are thrown away. Because no per-byte valid mask exists, this trimming is the only way a partial word is handled.

Misuse produces a one-cycle write-error pulse toward the interrupt logic. Misuse means a word written before any configuration, or a word written once the whole length has been consumed; such a word is accepted and discarded. A zero-length message produces a one-cycle end-of-message pulse and no bytes.

Top module: `msg_word_ingress`

## Requirements
- R1: While reset is held and after it is released, out_valid, wr_err and empty_msg are low, and wr_ready is high because the block is unconfigured.
- R2: A word accepted before the first configure strobe produces no output bytes, and wr_err is high for exactly the one cycle after the accepting edge.
- R3: wr_ready is low during the cycle in which cfg_strobe is high and during the SETUP_CYC cycles that follow it.
- R4: Lane n of a word is wr_data[8n+7:8n]. The output byte order by code is: 0 gives lanes 0,1,2,3; 1 gives lanes 3,2,1,0; 2 gives lanes 0,1,3,2; 3 gives lanes 2,3,0,1.
- R5: A word that is not the final word of the message yields exactly four output bytes, and out_last is low on all of them.
- R6: The message length in bytes is cfg_len_bits divided by 8 and rounded down. The final word yields only the bytes still owed (1 to 4), and out_last is high on the last of them only.
- R7: A word accepted after the full length has been consumed produces no output bytes, and it raises wr_err for one cycle.
- R8: A configure strobe with a zero byte length raises empty_msg for exactly the next cycle, and the block emits no bytes for that message.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold steady. While the block is configured, wr_ready stays low while more than one byte of the current word is still undelivered.
- R10: A configure strobe during a message discards all undelivered bytes; out_valid is low in the following cycle and the new message starts from its own length.
- R11: A word is accepted in the same cycle that the last byte of the previous word is taken. A 4-word burst with out_ready held high therefore emits 16 bytes on 16 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strobe | input | 1 | One-cycle pulse: control register written, new message starts |
| cfg_order | input | 2 | Byte-ordering code, latched on cfg_strobe |
| cfg_len_bits | input | LEN_W | Message length in bits, latched on cfg_strobe |
| wr_valid | input | 1 | Data word offered on the write port |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Write port can take a word this cycle |
| wr_err | output | 1 | One-cycle message-write-error pulse |
| out_valid | output | 1 | Byte offered to the hash core |
| out_data | output | 8 | Message byte |
| out_last | output | 1 | Marks the final byte of the message |
| out_ready | input | 1 | Hash core takes the byte this cycle |
| empty_msg | output | 1 | One-cycle end-of-message pulse for a zero-length message |

## Verification
The bench uses the defaults: a 64-bit length field and a two-cycle setup gap. With these values the ready hole after each strobe can be seen on the port. The lengths used cover every final-word size from one to four bytes, as well as a bit length that is not a whole number of bytes. Random stalls on out_ready exercise the hold and backpressure rules. The bench also uses a forced stall with a strobe in the middle of a message, and an unstalled four-word burst that shows whether the pipeline refills without a bubble.

// File: rtl/msg_word_ingress.sv
module msg_word_ingress #(
  parameter int LEN_W     = 64,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_strobe,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             wr_err,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             empty_msg
);
  localparam int SW = $clog2(SETUP_CYC + 1);

  logic             armed_q;
  logic [SW-1:0]    setup_q;
  logic [1:0]       order_q;
  logic [LEN_W-1:0] owed_q;
  logic [31:0]      word_q;
  logic [2:0]       held_q;
  logic             final_q;

  function automatic logic [31:0] lane_swap(input logic [1:0] code, input logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    {b3, b2, b1, b0} = w;
    case (code)
      2'd0:    lane_swap = w;
      2'd1:    lane_swap = {b0, b1, b2, b3};
      2'd2:    lane_swap = {b2, b3, b1, b0};
      default: lane_swap = {b1, b0, b3, b2};
    endcase
  endfunction

  logic       out_fire, room, wr_fire, load;
  logic [2:0] take_n;

  assign out_valid = held_q != 3'd0;
  assign out_data  = word_q[7:0];
  assign out_last  = final_q && held_q == 3'd1;
  assign out_fire  = out_valid && out_ready;

  assign room     = setup_q == '0 && (held_q == 3'd0 || (held_q == 3'd1 && out_ready));
  assign wr_ready = !cfg_strobe && (!armed_q || room);
  assign wr_fire  = wr_valid && wr_ready;
  assign load     = wr_fire && armed_q && owed_q != '0;
  assign take_n   = (owed_q >= LEN_W'(4)) ? 3'd4 : owed_q[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      setup_q   <= '0;
      order_q   <= 2'd0;
      owed_q    <= '0;
      word_q    <= '0;
      held_q    <= 3'd0;
      final_q   <= 1'b0;
      wr_err    <= 1'b0;
      empty_msg <= 1'b0;
    end else if (cfg_strobe) begin
      armed_q   <= 1'b1;
      setup_q   <= SW'(SETUP_CYC);
      order_q   <= cfg_order;
      owed_q    <= cfg_len_bits >> 3;
      held_q    <= 3'd0;
      final_q   <= 1'b0;
      wr_err    <= 1'b0;
      empty_msg <= (cfg_len_bits >> 3) == '0;
    end else begin
      empty_msg <= 1'b0;
      wr_err    <= wr_fire && !load;
      if (setup_q != '0)
        setup_q <= setup_q - 1'b1;
      if (load) begin
        word_q  <= lane_swap(order_q, wr_data);
        held_q  <= take_n;
        final_q <= owed_q <= LEN_W'(4);
        owed_q  <= owed_q - LEN_W'(take_n);
      end else if (out_fire) begin
        word_q <= {8'h00, word_q[31:8]};
        held_q <= held_q - 3'd1;
      end
    end
  end
endmodule

// File: rtl/msg_word_ingress_chk.sv
module msg_word_ingress_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_strobe,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       wr_err,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       empty_msg
);
  a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |=> !wr_ready);

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !cfg_strobe |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r2_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid && wr_ready));

  a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r8_empty_src: assert property (@(posedge clk) disable iff (!rst_n)
    empty_msg |-> $past(cfg_strobe) && !out_valid);

  a_r10_restart_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |=> !out_valid);
endmodule

bind msg_word_ingress msg_word_ingress_chk chk_i (.*);

// File: tb/msg_word_ingress_tb_top.sv
`timescale 1ns/1ps
module msg_word_ingress_tb_top;
  localparam int LEN_W = 64;
  localparam int SETUP_CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cfg_strobe = 1'b0;
  logic [1:0]       cfg_order = 2'd0;
  logic [LEN_W-1:0] cfg_len_bits = '0;
  logic             wr_valid = 1'b0;
  logic [31:0]      wr_data = '0;
  logic             wr_ready, wr_err, out_valid, out_last, empty_msg;
  logic [7:0]       out_data;
  logic             out_ready = 1'b1;

  msg_word_ingress #(.LEN_W(LEN_W), .SETUP_CYC(SETUP_CYC)) dut_i (.*);

  int    checks = 0, errors = 0;
  string tag = "R1";
  int    rdy_mode = 0;
  int    nbytes = 0, cyc = 0, first_fire = -1, last_fire = -1;

  bit         m_cfg = 0, m_err = 0, m_empty = 0;
  int         m_setup = 0;
  logic [1:0] m_ord = 0;
  longint     m_rem = 0;
  logic [8:0] m_q[$];

  function automatic bit exp_ready();
    return !cfg_strobe && (!m_cfg || (m_setup == 0 &&
           (m_q.size() == 0 || (m_q.size() == 1 && out_ready))));
  endfunction

  function automatic int lane_of(logic [1:0] code, int k);
    case (code)
      2'd0: return k;
      2'd1: return 3 - k;
      2'd2: return (k < 2) ? k : 5 - k;
      default: return k ^ 2;
    endcase
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_setup = 0; m_q.delete(); m_err = 0; m_empty = 0; m_rem = 0;
    end else begin
      bit fw, fo;
      fw = wr_valid && exp_ready();
      fo = m_q.size() != 0 && out_ready;
      if (cfg_strobe) begin
        m_cfg = 1; m_ord = cfg_order; m_rem = longint'(cfg_len_bits / 8);
        m_setup = SETUP_CYC; m_q.delete(); m_err = 0; m_empty = (m_rem == 0);
      end else begin
        if (m_setup > 0) m_setup--;
        m_empty = 0;
        m_err = fw && !(m_cfg && m_rem > 0);
        if (fo) void'(m_q.pop_front());
        if (fw && m_cfg && m_rem > 0) begin
          int n;
          n = (m_rem >= 4) ? 4 : int'(m_rem);
          for (int k = 0; k < n; k++)
            m_q.push_back({(k == n - 1) && (m_rem == n),
                           wr_data[8*lane_of(m_ord, k) +: 8]});
          m_rem -= n;
        end
      end
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    #0.5;
    cyc++;
    if (rst_n) begin
      chk("wr_ready", wr_ready, exp_ready());
      chk("out_valid", out_valid, m_q.size() != 0);
      chk("wr_err", wr_err, m_err);
      chk("empty_msg", empty_msg, m_empty);
      if (m_q.size() != 0) begin
        chk("out_data", out_data, m_q[0][7:0]);
        chk("out_last", out_last, m_q[0][8]);
      end
      if (out_valid && out_ready) begin
        nbytes++;
        if (first_fire < 0) first_fire = cyc;
        last_fire = cyc;
      end
    end
  end

  task automatic start_msg(logic [1:0] code, longint bits);
    @(negedge clk);
    cfg_strobe = 1'b1; cfg_order = code; cfg_len_bits = LEN_W'(bits);
    @(negedge clk);
    cfg_strobe = 1'b0;
  endtask

  task automatic send(logic [31:0] d);
    bit r;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    forever begin
      #0.8;
      r = wr_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic idle_wr();
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    int g = 0;
    while (m_q.size() != 0 && g < 2000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_case(string t);
    tag = t; nbytes = 0; first_fire = -1; last_fire = -1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act 1 exp 0");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    #0.5;
    chk("reset out_valid", out_valid, 0);
    chk("reset wr_err", wr_err, 0);
    chk("reset empty_msg", empty_msg, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk("post-reset wr_ready", wr_ready, 1);

    begin_case("R2");
    send(32'hDEADBEEF); idle_wr(); drain();
    chk("unconfigured byte count", nbytes, 0);

    begin_case("R3_R5_R6");
    start_msg(2'd0, 13 * 8);
    chk("ready in setup", wr_ready, 0);
    send(32'h03020100); send(32'h07060504); send(32'h0B0A0908); send(32'h0F0E0D0C);
    idle_wr(); drain();
    chk("13-byte count", nbytes, 13);

    for (int c = 1; c < 4; c++) begin
      begin_case("R4");
      rdy_mode = 1;
      start_msg(2'(c), 8 * 8);
      send(32'hA3A2A1A0); send(32'hB3B2B1B0); idle_wr(); drain();
      chk("order byte count", nbytes, 8);
    end

    for (int n = 5; n <= 8; n++) begin
      begin_case("R6");
      start_msg(2'(n % 4), n * 8 + (n == 5 ? 3 : 0));
      send(32'h44332211); send(32'h88776655); idle_wr(); drain();
      chk("trimmed byte count", nbytes, n);
    end

    begin_case("R7");
    send(32'h12345678); idle_wr(); drain();
    chk("overrun byte count", nbytes, 0);

    begin_case("R8");
    rdy_mode = 0;
    start_msg(2'd1, 7);
    #0.5;
    chk("empty pulse", empty_msg, 1);
    send(32'hCAFEF00D); idle_wr(); drain();
    chk("empty byte count", nbytes, 0);

    begin_case("R9_R10");
    rdy_mode = 2;
    start_msg(2'd0, 12 * 8);
    send(32'h11111111); idle_wr();
    repeat (4) @(negedge clk);
    start_msg(2'd3, 4 * 8);
    rdy_mode = 0;
    send(32'h0D0C0B0A); idle_wr(); drain();
    chk("restart byte count", nbytes, 4);

    begin_case("R11");
    start_msg(2'd0, 16 * 8);
    send(32'h03020100); send(32'h07060504); send(32'h0B0A0908); send(32'h0F0E0D0C);
    idle_wr(); drain();
    chk("burst byte count", nbytes, 16);
    chk("burst span cycles", last_fire - first_fire, 15);

    finish_run();
  end
endmodule